// File: doc/BRIEF.md
# Critical-Conduction PFC Gate Timing Controller

This block produces the gate drive for the switch of a boost power-factor stage that runs in critical conduction. Each switching cycle starts with an on-interval whose length comes from a digital error-amplifier code. The on-interval is lengthened while the line is near its zero crossing and is capped at a maximum. The block then waits for the inductor to demagnetise. A zero-crossing comparator first goes high and then low again, and that falling edge starts the next cycle.

If the comparator never completes a high-then-low pair, a watchdog forces a fresh on-pulse after a fixed number of clock cycles. It keeps doing so until normal zero-crossing operation returns. A bus overvoltage flag blanks the gate. Once the flag clears and the bus is reported below its regulation level, a forced pulse restarts switching. An enable input, driven low by the ballast supervisor in fault or lockout, holds the gate off. The analog loop and the comparators sit outside this block; their outputs arrive here as clean synchronous flags.

Top module: `pfc_gate_ctrl`

## Requirements
- R1: After reset the gate is low, and it stays low while enable is low.
- R2: When enable goes high with no overvoltage, the gate goes high at the next clock edge.
- R3: Each on-pulse lasts N = max(1, min(MAX_ON_CYC, on_code*TICK_CYC)) clock cycles while line_near_zero is low. The code is taken at the edge where the gate turns on.
- R4: If line_near_zero is high at the turn-on edge, EXT_TICKS ticks are added to the code before the clamp: N = min(MAX_ON_CYC, (on_code+EXT_TICKS)*TICK_CYC).
- R5: The on-pulse never exceeds MAX_ON_CYC cycles. With the defaults, code 63 gives 200 cycles.
- R6: In the off interval, a zx_cmp rise followed by a zx_cmp fall turns the gate on at the first clock edge that samples zx_cmp low.
- R7: zx_cmp edges during the on-pulse are ignored. The pulse width does not change, and a fall after turn-off whose rise came during the on-pulse does not start a cycle.
- R8: Without a valid zero-crossing pair, the gate stays low for exactly WDOG_CYC cycles after turn-off and then pulses. This repeats for every cycle without a valid pair.
- R9: While ovp_hi is high, the gate is low from the next clock edge onward. Neither zero crossings nor the watchdog can turn it on.
- R10: After ovp_hi clears, the gate stays low until bus_below_reg is high, and it then turns on at the next clock edge.
- R11: enable low forces the gate low from the next edge. Raising enable again restarts switching at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | High when the ballast is neither in fault nor in lockout |
| on_code | input | CODE_W | On-time code from the error amplifier, in ticks |
| line_near_zero | input | 1 | High while the line voltage is near its zero crossing |
| zx_cmp | input | 1 | Zero-crossing comparator output, hysteresis already applied |
| ovp_hi | input | 1 | Bus sense above the overvoltage level |
| bus_below_reg | input | 1 | Bus sense below the regulation level |
| gate | output | 1 | Switch gate command |

## Verification
The assertions check the following on every cycle:
- The gate falls one edge after enable drops or overvoltage rises.
- An on-pulse in progress survives any zero-crossing activity.
- An unarmed falling edge never starts a cycle.
- A valid falling edge always does.
- The blanking state holds the gate low until the bus is below regulation.
- The watchdog and on-time counters stay within their bounds.

Only the bench scenarios can show the following:
- The exact pulse widths for each code, with and without near-zero extension, and at the clamp.
- The exact low gap before a zero-crossing turn-on and before a watchdog turn-on.
- That a rise seen during the on-pulse leaves the next cycle to the watchdog.

// File: rtl/pfc_gate_pkg.sv
package pfc_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ON    = 2'd1,
    ST_WAIT  = 2'd2,
    ST_BLANK = 2'd3
  } pfc_state_e;

  // On-interval length in clock cycles: ticks times tick length, clamped, at least one cycle.
  function automatic int unsigned on_cycles(input int unsigned code,
                                            input logic        near_zero,
                                            input int unsigned tick_cyc,
                                            input int unsigned ext_ticks,
                                            input int unsigned max_on);
    int unsigned ticks;
    int unsigned cyc;
    ticks = code + (near_zero ? ext_ticks : 0);
    cyc   = ticks * tick_cyc;
    if (cyc > max_on) cyc = max_on;
    if (cyc == 0) cyc = 1;
    return cyc;
  endfunction

endpackage

// File: rtl/pfc_zx_edge.sv
module pfc_zx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic zx_in,
  output logic zx_rise,
  output logic zx_fall
);
  logic zx_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zx_prev <= 1'b0;
    else        zx_prev <= zx_in;
  end

  assign zx_rise = zx_in & ~zx_prev;
  assign zx_fall = ~zx_in & zx_prev;
endmodule

// File: rtl/pfc_watchdog.sv
module pfc_watchdog #(
  parameter int unsigned WDOG_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int unsigned WD_W = $clog2(WDOG_CYC + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_CYC - 1);

  logic [WD_W-1:0] wd_cnt;

  assign expire = run && (wd_cnt == WD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wd_cnt <= '0;
    else if (!run)    wd_cnt <= '0;
    else if (!expire) wd_cnt <= wd_cnt + 1'b1;
  end

  // R8: the low-interval count never passes the watchdog period
  a_r8_wd_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (wd_cnt <= WD_LAST));
endmodule

// File: rtl/pfc_on_timer.sv
module pfc_on_timer
  import pfc_gate_pkg::*;
#(
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned TICK_CYC   = 4,
  parameter int unsigned EXT_TICKS  = 3,
  parameter int unsigned MAX_ON_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic [CODE_W-1:0] code,
  input  logic              near_zero,
  output logic              done
);
  localparam int unsigned LEN_W = $clog2(MAX_ON_CYC + 1);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_calc;

  assign len_calc = LEN_W'(on_cycles(32'(code), near_zero, TICK_CYC, EXT_TICKS, MAX_ON_CYC));
  assign done     = active && (cnt_q == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= LEN_W'(1);
      cnt_q <= LEN_W'(1);
    end else if (start) begin
      len_q <= len_calc;
      cnt_q <= LEN_W'(1);
    end else if (active && !done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: the running count stays within the latched length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= len_q));
  // R5: the latched length is nonzero and at most the limit
  a_r5_len_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (len_q != '0 && 32'(len_q) <= MAX_ON_CYC));
endmodule

// File: rtl/pfc_gate_ctrl.sv
module pfc_gate_ctrl
  import pfc_gate_pkg::*;
#(
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned TICK_CYC   = 4,
  parameter int unsigned EXT_TICKS  = 3,
  parameter int unsigned MAX_ON_CYC = 200,
  parameter int unsigned WDOG_CYC   = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] on_code,
  input  logic              line_near_zero,
  input  logic              zx_cmp,
  input  logic              ovp_hi,
  input  logic              bus_below_reg,
  output logic              gate
);
  pfc_state_e st, st_nxt;
  logic armed;
  logic zx_rise, zx_fall;
  logic zx_valid_fall;
  logic wd_fire;
  logic on_done;
  logic start_evt;
  logic in_wait;

  pfc_zx_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .zx_in  (zx_cmp),
    .zx_rise(zx_rise),
    .zx_fall(zx_fall)
  );

  assign in_wait = (st == ST_WAIT);

  pfc_watchdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_wait),
    .expire(wd_fire)
  );

  pfc_on_timer #(
    .CODE_W    (CODE_W),
    .TICK_CYC  (TICK_CYC),
    .EXT_TICKS (EXT_TICKS),
    .MAX_ON_CYC(MAX_ON_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .active   (st == ST_ON),
    .code     (on_code),
    .near_zero(line_near_zero),
    .done     (on_done)
  );

  assign zx_valid_fall = in_wait && armed && zx_fall;

  always_comb begin
    start_evt = 1'b0;
    if (enable && !ovp_hi) begin
      unique case (st)
        ST_IDLE:  start_evt = 1'b1;
        ST_WAIT:  start_evt = zx_valid_fall || wd_fire;
        ST_BLANK: start_evt = bus_below_reg;
        default:  start_evt = 1'b0;
      endcase
    end
  end

  always_comb begin
    st_nxt = st;
    if (!enable)        st_nxt = ST_IDLE;
    else if (ovp_hi)    st_nxt = ST_BLANK;
    else if (start_evt) st_nxt = ST_ON;
    else if (st == ST_ON && on_done) st_nxt = ST_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      armed <= 1'b0;
    end else begin
      st <= st_nxt;
      if (!in_wait)     armed <= 1'b0;
      else if (zx_rise) armed <= 1'b1;
    end
  end

  assign gate = (st == ST_ON);

  // R11: dropping enable turns the gate off at the next edge
  a_r11_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gate);
  // R9: overvoltage blanks the gate at the next edge
  a_r9_ovp_blank: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_hi |=> !gate);
  // R7: an unfinished on-pulse continues whatever the comparator does
  a_r7_on_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON && !on_done && enable && !ovp_hi) |=> gate);
  // R6: without an arming rise only the watchdog may end the off interval
  a_r6_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !armed && !wd_fire) |=> !gate);
  // R6: a valid falling edge starts the next pulse
  a_r6_valid_start: assert property (@(posedge clk) disable iff (!rst_n)
    (zx_valid_fall && enable && !ovp_hi) |=> gate);
  // R8: watchdog expiry forces a pulse
  a_r8_wd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fire && enable && !ovp_hi) |=> gate);
  // R10: blanking persists until the bus is below regulation
  a_r10_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BLANK && !bus_below_reg) |=> !gate);
endmodule

// File: tb/pfc_gate_ctrl_test.sv
`timescale 1ns/1ps
module pfc_gate_ctrl_test;
  localparam int CODE_W = 6;
  localparam int WDOG   = 300;

  logic clk = 1'b0;
  logic rst_n, enable, line_near_zero, zx_cmp, ovp_hi, bus_below_reg;
  logic [CODE_W-1:0] on_code;
  logic gate;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  int hi_cnt = 0;
  int lo_cnt = 0;
  int last_gap = 0;
  int rises = 0;
  int pulses_done = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pfc_gate_ctrl #(.CODE_W(CODE_W), .TICK_CYC(4), .EXT_TICKS(3),
                  .MAX_ON_CYC(200), .WDOG_CYC(WDOG)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .on_code(on_code),
    .line_near_zero(line_near_zero), .zx_cmp(zx_cmp), .ovp_hi(ovp_hi),
    .bus_below_reg(bus_below_reg), .gate(gate));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected width from the requirements (R3, R4, R5)
  function automatic int width_of(input int code, input bit nz);
    int w;
    w = (code + (nz ? 3 : 0)) * 4;
    if (w > 200) w = 200;
    if (w < 1) w = 1;
    return w;
  endfunction

  // Monitor: measures pulses and gaps, pops the scoreboard at each pulse end
  always @(negedge clk) begin
    if (rst_n) begin
      if (gate) begin
        if (hi_cnt == 0) begin
          last_gap = lo_cnt;
          rises++;
        end
        hi_cnt++;
        lo_cnt = 0;
      end else begin
        if (hi_cnt != 0) begin
          if (exp_q.size() == 0) check(0, "R3 unexpected pulse", hi_cnt, 0);
          else begin
            int e;
            e = exp_q.pop_front();
            check(hi_cnt == e, "R3/R4/R5 pulse width", hi_cnt, e);
          end
          pulses_done++;
        end
        hi_cnt = 0;
        lo_cnt++;
      end
    end
  end

  task automatic wait_end();
    int n;
    n = pulses_done;
    wait (pulses_done > n);
  endtask

  task automatic wait_rise();
    int n;
    n = rises;
    wait (rises > n);
  endtask

  task automatic zx_pair();
    repeat (3) @(negedge clk);
    zx_cmp = 1'b1;
    repeat (2) @(negedge clk);
    zx_cmp = 1'b0;
  endtask

  task automatic hold_low(input int n, input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gate) bad++;
      if (i == 50) zx_cmp = 1'b1;
      if (i == 55) zx_cmp = 1'b0;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; on_code = 6'd10; line_near_zero = 1'b0;
    zx_cmp = 1'b0; ovp_hi = 1'b0; bus_below_reg = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(gate == 1'b0, "R1 gate low after reset", gate, 0);

    // R2 / R3: enable starts a pulse of code*tick
    exp_q.push_back(width_of(10, 0));
    enable = 1'b1;
    @(negedge clk);
    check(gate == 1'b1, "R2 start on enable", gate, 1);
    wait_end();

    // R6: valid zero-crossing pair starts the next cycle
    on_code = 6'd20;
    exp_q.push_back(width_of(20, 0));
    repeat (5) @(negedge clk);
    zx_cmp = 1'b1;
    repeat (3) @(negedge clk);
    check(gate == 1'b0, "R6 low before fall", gate, 0);
    zx_cmp = 1'b0;
    @(negedge clk);
    check(gate == 1'b1, "R6 turn-on after fall", gate, 1);
    @(negedge clk);
    check(last_gap == 9, "R6 off-gap length", last_gap, 9);

    // R7: rise during on-time is ignored; later fall does not trigger -> watchdog (R8)
    repeat (8) @(negedge clk);
    zx_cmp = 1'b1;
    on_code = 6'd5;
    exp_q.push_back(width_of(5, 0));
    wait_end();
    repeat (5) @(negedge clk);
    zx_cmp = 1'b0;
    wait_rise();
    check(last_gap == WDOG, "R7 stale fall ignored, watchdog gap", last_gap, WDOG);
    wait_end();
    exp_q.push_back(width_of(5, 0));
    wait_rise();
    check(last_gap == WDOG, "R8 repeated watchdog gap", last_gap, WDOG);
    wait_end();

    // R4: near-zero extension
    line_near_zero = 1'b1;
    exp_q.push_back(width_of(5, 1));
    zx_pair();
    wait_end();
    line_near_zero = 1'b0;

    // R5: clamp at the on-time limit
    on_code = 6'd63;
    exp_q.push_back(width_of(63, 0));
    zx_pair();
    wait_end();

    // R3: zero code gives a one-cycle pulse
    on_code = 6'd0;
    exp_q.push_back(width_of(0, 0));
    zx_pair();
    wait_end();

    // R9 / R10: overvoltage blanking and forced restart
    on_code = 6'd10;
    repeat (3) @(negedge clk);
    ovp_hi = 1'b1;
    bus_below_reg = 1'b0;
    hold_low(400, "R9 gate held low during overvoltage");
    ovp_hi = 1'b0;
    hold_low(20, "R10 low until bus below regulation");
    exp_q.push_back(width_of(10, 0));
    bus_below_reg = 1'b1;
    @(negedge clk);
    check(gate == 1'b1, "R10 forced pulse on release", gate, 1);
    wait_end();

    // R11: disable holds off, re-enable restarts at once
    repeat (3) @(negedge clk);
    enable = 1'b0;
    hold_low(400, "R11 gate low while disabled");
    exp_q.push_back(width_of(10, 0));
    enable = 1'b1;
    @(negedge clk);
    check(gate == 1'b1, "R11 restart on re-enable", gate, 1);
    wait_end();

    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule